// File: doc/BRIEF.md
# Repeater Status and Utilization LED Controller

This block turns the status flags of a four-port repeater into active-low LED drive levels. Each port has a link/activity lamp and an error lamp. There is one collision lamp and a five-step utilization bar. A port's two lamps together encode one of six conditions: no signal, signal without descrambler lock, link idle, link receiving, faulted port, and bad receive data. Some conditions use steady lamps and some use blink patterns.

All lamps are refreshed together at the end of each hold period of `HOLD_CYC` clocks (40 ms in the target system). This gives every on or off state a visible minimum length. The same period drives the blink phase. Single-cycle events that occur during a period are remembered until the period ends. Utilization is the count of clocks with repeater activity over a window of 2^`WIN_LOG2` clocks. It is compared against five uneven thresholds and the result is latched when the window ends.

Top module: `led_status_ctrl`

## Requirements
- R1: All lamp outputs are active low (0 = lit). While reset is held, and after reset until the first hold period ends, every output is 1.
- R2: Outputs change only at the end of a hold period of HOLD_CYC clocks, counted from reset release. Periods are numbered from 0. The value shown after period p ends is built from the levels in the last clock of period p and from the events seen anywhere in period p. Blink phase of period p is p mod 2. A "blink-on" lamp is lit when the phase is 1. A "blink-off" lamp is lit when the phase is 0.
- R3: With sig_det low, both lamps of the port are dark.
- R4: With sig_det high and idle_lock low, the link lamp is dark and the error lamp blinks on. This holds even if port_fault is high.
- R5: With a link (sig_det and idle_lock high) and no event or fault, the link lamp is lit steady and the error lamp is dark.
- R6: With a link and a receive-packet event in the period, the link lamp blinks off and the error lamp is dark.
- R7: With a link and port_fault high, both lamps are lit steady, whatever events occur.
- R8: With a link, no fault, and a bad-data event in the period, the link lamp blinks off and the error lamp blinks on. This takes precedence over a packet event.
- R9: A one-clock rx_pkt, rx_err, col_local or col_stack pulse anywhere in a period affects the value shown for that period.
- R10: The collision lamp is lit for a period exactly when col_local or col_stack was seen in it.
- R11: Bar step i (util_led_n[i]) is lit when A·d_i > W·n_i. Here A is the number of active clocks in the window and W = 2^WIN_LOG2. The fractions n_i/d_i for i = 0..4 are 1/100, 1/8, 1/4, 1/2 and 3/5. The result is latched when the window ends, shown from the next period end, and all dark before the first window closes.
- R12: The bar is a thermometer: step i+1 is never lit while step i is dark.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| sig_det | input | NPORTS | Per-port received-signal present |
| idle_lock | input | NPORTS | Per-port descrambler locked on idle (link established) |
| port_fault | input | NPORTS | Per-port partitioned, isolated or jabber shutdown |
| rx_pkt | input | NPORTS | Per-port packet-received event |
| rx_err | input | NPORTS | Per-port false-carrier or invalid-data event |
| rep_active | input | 1 | Repeater-wide activity, one clock per sample |
| col_local | input | 1 | Collision seen locally |
| col_stack | input | 1 | Collision reported elsewhere in the stack |
| act_led_n | output | NPORTS | Per-port link/activity lamp, active low |
| err_led_n | output | NPORTS | Per-port error lamp, active low |
| col_led_n | output | 1 | Collision lamp, active low |
| util_led_n | output | 5 | Utilization bar, active low, bit 0 lowest step |

## Verification
Each port is rotated through eight conditions, and the four ports are offset so that all conditions appear on both blink phases. The fault condition is applied both with and without lock, and with an error pulse added, which separates lock priority from fault priority. Packet and error pulses are applied together, which separates error precedence from packet handling. Utilization windows are filled with active counts of 0, 1, 8, 9, 38, 39 and 64 clocks, which sit on either side of the 1%, 12.5% and 60% steps and test the strict comparison. A mid-period sample checks that no output moves between period ends.

// File: rtl/led_stat_pkg.sv
package led_stat_pkg;

  localparam int UTIL_STEPS = 5;

  // Threshold fraction numerator/denominator per utilization step.
  function automatic int unsigned util_num(int idx);
    case (idx)
      4:       return 3;
      default: return 1;
    endcase
  endfunction

  function automatic int unsigned util_den(int idx);
    case (idx)
      0:       return 100;
      1:       return 8;
      2:       return 4;
      3:       return 2;
      default: return 5;
    endcase
  endfunction

  typedef enum logic [2:0] {
    PS_NOSIG,
    PS_NOLOCK,
    PS_FAULT,
    PS_BADRX,
    PS_RXPKT,
    PS_IDLE
  } port_state_e;

endpackage

// File: rtl/led_hold_timer.sv
module led_hold_timer #(
  parameter int HOLD_CYC = 2_000_000
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick,
  output logic phase
);
  localparam int CW = (HOLD_CYC > 1) ? $clog2(HOLD_CYC) : 1;

  logic [CW-1:0] cnt_q, cnt_d;
  logic          phase_q, phase_d;

  assign tick  = (cnt_q == CW'(HOLD_CYC - 1));
  assign phase = phase_q;

  always_comb begin
    cnt_d   = tick ? '0 : cnt_q + 1'b1;
    phase_d = tick ? ~phase_q : phase_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      phase_q <= phase_d;
    end
  end
endmodule

// File: rtl/led_port_lamp.sv
module led_port_lamp
  import led_stat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic phase,
  input  logic sig_det,
  input  logic idle_lock,
  input  logic port_fault,
  input  logic rx_pkt,
  input  logic rx_err,
  output logic act_led_n,
  output logic err_led_n
);
  logic        pkt_seen_q, pkt_seen_d;
  logic        err_seen_q, err_seen_d;
  logic        act_q, act_d;
  logic        erl_q, erl_d;
  logic        pkt_any, err_any;
  logic        act_on, err_on;
  port_state_e st;

  always_comb begin
    pkt_any    = pkt_seen_q | rx_pkt;
    err_any    = err_seen_q | rx_err;
    pkt_seen_d = tick ? 1'b0 : pkt_any;
    err_seen_d = tick ? 1'b0 : err_any;

    if (!sig_det)        st = PS_NOSIG;
    else if (!idle_lock) st = PS_NOLOCK;
    else if (port_fault) st = PS_FAULT;
    else if (err_any)    st = PS_BADRX;
    else if (pkt_any)    st = PS_RXPKT;
    else                 st = PS_IDLE;

    case (st)
      PS_NOLOCK: begin act_on = 1'b0;   err_on = phase;  end
      PS_FAULT:  begin act_on = 1'b1;   err_on = 1'b1;   end
      PS_BADRX:  begin act_on = ~phase; err_on = phase;  end
      PS_RXPKT:  begin act_on = ~phase; err_on = 1'b0;   end
      PS_IDLE:   begin act_on = 1'b1;   err_on = 1'b0;   end
      default:   begin act_on = 1'b0;   err_on = 1'b0;   end
    endcase

    act_d = tick ? ~act_on : act_q;
    erl_d = tick ? ~err_on : erl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pkt_seen_q <= 1'b0;
      err_seen_q <= 1'b0;
      act_q      <= 1'b1;
      erl_q      <= 1'b1;
    end else begin
      pkt_seen_q <= pkt_seen_d;
      err_seen_q <= err_seen_d;
      act_q      <= act_d;
      erl_q      <= erl_d;
    end
  end

  assign act_led_n = act_q;
  assign err_led_n = erl_q;
endmodule

// File: rtl/led_util_meter.sv
module led_util_meter
  import led_stat_pkg::*;
#(
  parameter int WIN_LOG2 = 20
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  active,
  output logic [UTIL_STEPS-1:0] util_lvl
);
  localparam int CW = WIN_LOG2 + 1;

  logic [WIN_LOG2-1:0]   win_q, win_d;
  logic [CW-1:0]         acc_q, acc_d;
  logic [CW-1:0]         total;
  logic                  last;
  logic [UTIL_STEPS-1:0] lvl_d;
  logic [UTIL_STEPS-1:0] lvl_q, lvl_nx;

  assign last  = &win_q;
  assign total = acc_q + CW'(active);

  for (genvar g = 0; g < UTIL_STEPS; g++) begin : g_thr
    localparam longint unsigned RHS = (64'd1 << WIN_LOG2) * 64'(util_num(g));
    localparam longint unsigned DEN = 64'(util_den(g));
    assign lvl_d[g] = (64'(total) * DEN) > RHS;
  end

  always_comb begin
    win_d  = win_q + 1'b1;
    acc_d  = last ? '0 : total;
    lvl_nx = last ? lvl_d : lvl_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q <= '0;
      acc_q <= '0;
      lvl_q <= '0;
    end else begin
      win_q <= win_d;
      acc_q <= acc_d;
      lvl_q <= lvl_nx;
    end
  end

  assign util_lvl = lvl_q;
endmodule

// File: rtl/led_status_ctrl.sv
module led_status_ctrl
  import led_stat_pkg::*;
#(
  parameter int NPORTS   = 4,
  parameter int HOLD_CYC = 2_000_000,
  parameter int WIN_LOG2 = 20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NPORTS-1:0] sig_det,
  input  logic [NPORTS-1:0] idle_lock,
  input  logic [NPORTS-1:0] port_fault,
  input  logic [NPORTS-1:0] rx_pkt,
  input  logic [NPORTS-1:0] rx_err,
  input  logic              rep_active,
  input  logic              col_local,
  input  logic              col_stack,
  output logic [NPORTS-1:0] act_led_n,
  output logic [NPORTS-1:0] err_led_n,
  output logic              col_led_n,
  output logic [4:0]        util_led_n
);
  logic                  tick, phase;
  logic [UTIL_STEPS-1:0] util_lvl;
  logic                  col_seen_q, col_seen_d, col_any;
  logic                  col_q, col_d;
  logic [4:0]            util_q, util_d;

  led_hold_timer #(.HOLD_CYC(HOLD_CYC)) u_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .phase(phase)
  );

  for (genvar p = 0; p < NPORTS; p++) begin : g_port
    led_port_lamp u_lamp (
      .clk(clk), .rst_n(rst_n), .tick(tick), .phase(phase),
      .sig_det(sig_det[p]), .idle_lock(idle_lock[p]),
      .port_fault(port_fault[p]), .rx_pkt(rx_pkt[p]), .rx_err(rx_err[p]),
      .act_led_n(act_led_n[p]), .err_led_n(err_led_n[p])
    );
  end

  led_util_meter #(.WIN_LOG2(WIN_LOG2)) u_util (
    .clk(clk), .rst_n(rst_n), .active(rep_active), .util_lvl(util_lvl)
  );

  always_comb begin
    col_any    = col_seen_q | col_local | col_stack;
    col_seen_d = tick ? 1'b0 : col_any;
    col_d      = tick ? ~col_any : col_q;
    util_d     = tick ? ~util_lvl : util_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col_seen_q <= 1'b0;
      col_q      <= 1'b1;
      util_q     <= '1;
    end else begin
      col_seen_q <= col_seen_d;
      col_q      <= col_d;
      util_q     <= util_d;
    end
  end

  assign col_led_n  = col_q;
  assign util_led_n = util_q;
endmodule

// File: rtl/led_status_chk.sv
module led_status_chk #(
  parameter int NPORTS   = 4,
  parameter int HOLD_CYC = 2_000_000
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NPORTS-1:0] sig_det,
  input logic [NPORTS-1:0] idle_lock,
  input logic [NPORTS-1:0] act_led_n,
  input logic [NPORTS-1:0] err_led_n,
  input logic              col_led_n,
  input logic [4:0]        util_led_n
);
  localparam int OW = 2 * NPORTS + 6;

  logic [OW-1:0] outs, prev_q;
  logic [31:0]   since_q;
  logic          chg;

  assign outs = {act_led_n, err_led_n, col_led_n, util_led_n};
  assign chg  = (outs != prev_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q  <= '1;
      since_q <= '0;
    end else begin
      prev_q  <= outs;
      if (chg)                  since_q <= '0;
      else if (since_q != '1)   since_q <= since_q + 1'b1;
    end
  end

  // R2: any output change is at least one hold period after the previous one
  assert_min_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    chg |-> (since_q >= 32'(HOLD_CYC - 1)));

  for (genvar p = 0; p < NPORTS; p++) begin : g_pchk
    // R5: link lamp only lights for a locked port with signal
    assert_link_needs_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(act_led_n[p]) |-> $past(sig_det[p] && idle_lock[p]));
    // R3: error lamp never lights without a signal
    assert_err_needs_sig_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(err_led_n[p]) |-> $past(sig_det[p]));
  end

  for (genvar g = 0; g < 4; g++) begin : g_uchk
    // R12: utilization bar is a thermometer
    assert_bar_thermo_R12: assert property (@(posedge clk) disable iff (!rst_n)
      !util_led_n[g+1] |-> !util_led_n[g]);
  end
endmodule

bind led_status_ctrl led_status_chk #(.NPORTS(NPORTS), .HOLD_CYC(HOLD_CYC)) u_chk (
  .clk(clk), .rst_n(rst_n), .sig_det(sig_det), .idle_lock(idle_lock),
  .act_led_n(act_led_n), .err_led_n(err_led_n),
  .col_led_n(col_led_n), .util_led_n(util_led_n)
);

// File: tb/led_status_ctrl_tb.sv
module led_status_ctrl_tb;
  localparam int NP   = 4;
  localparam int HOLD = 8;
  localparam int WL   = 6;
  localparam int WIN  = 64;
  localparam int NPER = 57;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n;
  logic [NP-1:0] sig_det, idle_lock, port_fault, rx_pkt, rx_err;
  logic          rep_active, col_local, col_stack;
  logic [NP-1:0] act_led_n, err_led_n;
  logic          col_led_n;
  logic [4:0]    util_led_n;

  led_status_ctrl #(.NPORTS(NP), .HOLD_CYC(HOLD), .WIN_LOG2(WL)) u_dut (
    .clk(clk), .rst_n(rst_n), .sig_det(sig_det), .idle_lock(idle_lock),
    .port_fault(port_fault), .rx_pkt(rx_pkt), .rx_err(rx_err),
    .rep_active(rep_active), .col_local(col_local), .col_stack(col_stack),
    .act_led_n(act_led_n), .err_led_n(err_led_n),
    .col_led_n(col_led_n), .util_led_n(util_led_n)
  );

  typedef struct {
    logic [NP-1:0] act;
    logic [NP-1:0] err;
    logic          col;
    logic [4:0]    util;
    int            per;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 0;
  int   tot[8] = '{1, 8, 9, 38, 39, 64, 0, 0};

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp, int per);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s period %0d: actual=%h expected=%h", req, per, act, exp);
    end
  endtask

  // R11: step i lit when A*d_i > W*n_i
  function automatic logic [4:0] util_exp(int a);
    int num[5] = '{1, 1, 1, 1, 3};
    int den[5] = '{100, 8, 4, 2, 5};
    logic [4:0] n;
    for (int i = 0; i < 5; i++) n[i] = !(a * den[i] > WIN * num[i]);
    return n;
  endfunction

  task automatic apply(int p);
    exp_t e;
    int   ph = p % 2;
    int   w  = p / 8;
    int   rem = tot[w % 8] - 8 * (p % 8);
    int   na = (rem < 0) ? 0 : ((rem > HOLD) ? HOLD : rem);
    for (int i = 0; i < NP; i++) begin
      int st = (p + 3 * i) % 8;
      logic a_on, e_on;
      sig_det[i] = (st != 0); idle_lock[i] = !(st == 0 || st == 1 || st == 7);
      port_fault[i] = (st == 4 || st == 7);
      rx_pkt[i] = (st == 3 || st == 6); rx_err[i] = (st == 4 || st == 5 || st == 6);
      case (st)
        0:       begin a_on = 0;       e_on = 0;       end // R3
        1, 7:    begin a_on = 0;       e_on = (ph==1); end // R4
        2:       begin a_on = 1;       e_on = 0;       end // R5
        3:       begin a_on = (ph==0); e_on = 0;       end // R6
        4:       begin a_on = 1;       e_on = 1;       end // R7
        default: begin a_on = (ph==0); e_on = (ph==1); end // R8
      endcase
      e.act[i] = ~a_on; e.err[i] = ~e_on;
    end
    col_local = (p % 3 == 1); col_stack = (p % 3 == 2);
    e.col  = (p % 3 == 0);                              // R10
    e.util = (w == 0) ? 5'h1f : util_exp(tot[w - 1]);   // R11
    e.per  = p;
    q.push_back(e);
    for (int c = 0; c < HOLD; c++) begin
      if (c == 1) begin  // R9: one-clock pulses only
        rx_pkt = '0; rx_err = '0; col_local = 0; col_stack = 0;
      end
      rep_active = (c < na);
      @(negedge clk);
    end
  endtask

  // Monitor / scoreboard
  initial begin
    int cyc = 0;
    logic [2*NP+5:0] last_out = '1;
    exp_t e;
    wait (rst_n === 1'b1);
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc == HOLD - 1 || (cyc > HOLD && cyc % HOLD == HOLD / 2)) begin
        @(negedge clk);
        chk("R2 stable", {act_led_n, err_led_n, col_led_n, util_led_n}, last_out, cyc / HOLD);
      end else if (cyc % HOLD == 0) begin
        @(negedge clk);
        if (q.size() > 0) begin
          e = q.pop_front();
          chk("R3-R8 act", act_led_n, e.act, e.per);
          chk("R3-R8 err", err_led_n, e.err, e.per);
          chk("R10 col",   col_led_n, e.col, e.per);
          chk("R11 util",  util_led_n, e.util, e.per);
        end
        last_out = {act_led_n, err_led_n, col_led_n, util_led_n};
      end
    end
  end

  initial begin
    repeat (4000) @(posedge clk);
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; sig_det = '0; idle_lock = '0; port_fault = '0;
    rx_pkt = '0; rx_err = '0; rep_active = 0; col_local = 0; col_stack = 0;
    repeat (3) @(negedge clk);
    // R1: reset state, all dark
    chk("R1 reset", {act_led_n, err_led_n, col_led_n, util_led_n}, {(2*NP+6){1'b1}}, 0);
    rst_n = 1;
    for (int p = 0; p < NPER; p++) apply(p);
    repeat (2) @(negedge clk);
    chk("R2 drained", 32'(q.size()), 32'd0, NPER);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule